// File: doc/BRIEF.md
# Dual-Address DMA Transfer Engine

A single-channel DMA engine that moves each transfer unit in two phases. First it reads the source into an internal holding register. Then it writes that register to the destination. It handles three directions: memory to memory, memory to I/O, and I/O to memory. The I/O port width is set apart from the transfer unit. When the port is narrower than the unit, the engine packs several narrow I/O reads into one unit, or unpacks one unit into several narrow I/O writes. It also splits a 32-bit unit into two 16-bit accesses when the memory is flagged as 16 bits wide.

Software sets the configuration inputs and pulses `start`. If the configuration is legal, the channel latches it and runs. In external mode it waits for `dreq` before each unit and answers with a one-cycle `dack`. In internal mode it runs the units back to back. Every bus access is a request held until `bus_rdy`. Read data is taken from the low-order bits of `bus_rdata`, and write data is driven on the low-order bits of `bus_wdata`. The size code is 0 for a byte, 1 for a halfword and 2 for a word. When the last unit has been written, `done` pulses for one cycle and the channel returns to idle.

Top module: `dual_addr_dma`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `dack`, `cfg_err` and `bus_req` are all low.
- R2: For each unit, every read access completes before the first write access. The bytes written equal the bytes read, in the same order, and no access beyond the expected sequence is issued.
- R3: `cfg_unit32`=1 selects a 4-byte unit and 0 selects a 2-byte unit. With `cfg_internal`=1 the unit is always 4 bytes, the channel never waits on `dreq`, and it never pulses `dack`.
- R4: In external mode, no bus access starts while `dreq` is low. Each unit is preceded by exactly one `dack` pulse, one cycle wide, raised only after `dreq` was seen high.
- R5: When the port size equals the unit, or for memory-to-memory transfers, a unit takes one read and one write, each of the unit size.
- R6: When the port (`cfg_port` 0=8, 1=16, 2=32 bits) is narrower than the unit, the I/O side takes unit/port accesses. The lowest byte comes first, and the I/O address rises by the port size between accesses.
- R7: With `cfg_mem16`=1 and a 4-byte unit, each memory access is split into two halfword accesses at addresses +0 and +2, low half first.
- R8: After each unit, both addresses advance by the unit size and the remaining count falls by it. When the count reaches zero, `done` pulses once, `busy` drops, and the channel issues no further access or `dack`.
- R9: A `start` with an illegal configuration sets `cfg_err` and the channel stays idle. Illegal means any of: a port wider than the unit on an I/O direction, `cfg_port`=3, `cfg_dir`=3 (0=mem-mem, 1=mem-I/O, 2=I/O-mem), a zero count, or a count that is not a multiple of the unit. A later legal `start` clears `cfg_err`.
- R10: While `bus_req` is high and `bus_rdy` is low, the address, direction and size stay unchanged, and the size code is never 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, sampled when idle |
| cfg_unit32 | input | 1 | Transfer unit 32 bits (1) or 16 bits (0) |
| cfg_internal | input | 1 | Internal request source; forces a 32-bit unit |
| cfg_mem16 | input | 1 | Memory is 16 bits wide |
| cfg_port | input | 2 | I/O port width code: 0=8, 1=16, 2=32 |
| cfg_dir | input | 2 | Direction: 0 mem-mem, 1 mem-I/O, 2 I/O-mem |
| cfg_src | input | ADDR_W | Source start address |
| cfg_dst | input | ADDR_W | Destination start address |
| cfg_count | input | CNT_W | Total byte count |
| dreq | input | 1 | External transfer request |
| dack | output | 1 | One-cycle request acknowledge |
| busy | output | 1 | Channel active |
| done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | Last start attempt was refused |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Access is a write |
| bus_size | output | 2 | Access size code: 0 byte, 1 half, 2 word |
| bus_addr | output | ADDR_W | Access address |
| bus_wdata | output | 32 | Write data, low-aligned |
| bus_rdata | input | 32 | Read data, low-aligned |
| bus_rdy | input | 1 | Access completes this cycle |

## Verification
Memory-to-memory runs with 32-bit and 16-bit units set the baseline of one read and one write per unit. I/O-to-memory and memory-to-I/O runs with 8-bit and 16-bit ports separate correct byte packing order and I/O address stepping from mistakes in either. Runs with 16-bit memory show whether the halfword split happens on the memory side only. An internal-request run with a 16-bit unit setting shows the forced word unit and the absence of the handshake. Stalled-ready runs, illegal configurations and a legal restart cover the held bus, refused starts and clearing of the error flag.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int BUS_BYTES = 4;
    localparam int OFF_W     = $clog2(BUS_BYTES);

    typedef enum logic [1:0] {
        DIR_M2M  = 2'd0,
        DIR_M2IO = 2'd1,
        DIR_IO2M = 2'd2,
        DIR_BAD  = 2'd3
    } dir_e;

    typedef enum logic [1:0] {
        PW_8   = 2'd0,
        PW_16  = 2'd1,
        PW_32  = 2'd2,
        PW_BAD = 2'd3
    } pw_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAITREQ,
        ST_ACK,
        ST_READ,
        ST_WRITE
    } st_e;

    // Per-unit access plan derived from a configuration
    typedef struct packed {
        logic [1:0] rd_sz;
        logic [2:0] rd_beats;
        logic [1:0] wr_sz;
        logic [2:0] wr_beats;
        logic [2:0] unit_bytes;
    } plan_t;

    function automatic logic [2:0] pw_bytes(input pw_e p);
        case (p)
            PW_8:    return 3'd1;
            PW_16:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [1:0] bytes_to_sz(input logic [2:0] b);
        case (b)
            3'd1:    return 2'd0;
            3'd2:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/dma_cfg_chk.sv
module dma_cfg_chk
    import dma_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             unit32,
    input  logic             internal,
    input  logic             mem16,
    input  logic [1:0]       port,
    input  logic [1:0]       dir,
    input  logic [CNT_W-1:0] count,
    output logic             legal,
    output plan_t            plan
);
    logic       eff32, src_io, dst_io, is_io, misalign;
    logic [2:0] ub, mb, pb, rb, wb;
    pw_e        pw;
    dir_e       dr;

    always_comb begin
        pw     = pw_e'(port);
        dr     = dir_e'(dir);
        eff32  = unit32 | internal;
        ub     = eff32 ? 3'd4 : 3'd2;
        mb     = (eff32 && mem16) ? 3'd2 : ub;
        pb     = pw_bytes(pw);
        src_io = (dr == DIR_IO2M);
        dst_io = (dr == DIR_M2IO);
        is_io  = src_io | dst_io;
        rb     = src_io ? pb : mb;
        wb     = dst_io ? pb : mb;

        plan.unit_bytes = ub;
        plan.rd_sz      = bytes_to_sz(rb);
        plan.wr_sz      = bytes_to_sz(wb);
        plan.rd_beats   = ub >> plan.rd_sz;
        plan.wr_beats   = ub >> plan.wr_sz;

        misalign = eff32 ? (count[1:0] != 2'd0) : count[0];
        legal    = (dr != DIR_BAD)
                 && !(is_io && ((pw == PW_BAD) || (pb > ub)))
                 && (count != '0)
                 && !misalign;
    end
endmodule

// File: rtl/dma_hold.sv
module dma_hold
    import dma_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [OFF_W-1:0]  ld_off,
    input  logic [1:0]        ld_sz,
    input  logic [DATA_W-1:0] din,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] dout
);
    localparam int NB = DATA_W / 8;

    logic [DATA_W-1:0] hold;
    logic [DATA_W-1:0] shifted;
    logic [OFF_W:0]    n_bytes;
    logic [OFF_W:0]    lo, hi;

    assign shifted = din << {ld_off, 3'b000};
    assign n_bytes = {{OFF_W{1'b0}}, 1'b1} << ld_sz;
    assign lo      = {1'b0, ld_off};
    assign hi      = lo + n_bytes;
    assign dout    = hold >> {rd_off, 3'b000};

    for (genvar i = 0; i < NB; i++) begin : g_lane
        localparam logic [OFF_W:0] IDX = (OFF_W+1)'(i);
        logic [7:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst)
                lane_q <= '0;
            else if (ld && (IDX >= lo) && (IDX < hi))
                lane_q <= shifted[i*8 +: 8];
        end
        assign hold[i*8 +: 8] = lane_q;
    end
endmodule

// File: rtl/dma_ctl.sv
module dma_ctl
    import dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              legal,
    input  plan_t             plan_in,
    input  logic              internal_in,
    input  logic [ADDR_W-1:0] src_in,
    input  logic [ADDR_W-1:0] dst_in,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              dreq,
    input  logic              bus_rdy,
    output logic              dack,
    output logic              busy,
    output logic              done,
    output logic              cfg_err,
    output logic              bus_req,
    output logic              bus_we,
    output logic [1:0]        bus_size,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              ld,
    output logic [OFF_W-1:0]  off
);
    st_e               st;
    plan_t             plan_q;
    logic              int_q;
    logic [ADDR_W-1:0] src_q, dst_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [OFF_W-1:0]  beat;
    logic              done_q, err_q;

    logic [2:0]        cur_beats;
    logic [OFF_W+2:0]  off_full;
    logic              last;
    logic [ADDR_W-1:0] ustep;
    logic [CNT_W-1:0]  ucnt;

    always_comb begin
        bus_req   = (st == ST_READ) || (st == ST_WRITE);
        bus_we    = (st == ST_WRITE);
        bus_size  = bus_we ? plan_q.wr_sz : plan_q.rd_sz;
        cur_beats = bus_we ? plan_q.wr_beats : plan_q.rd_beats;
        off_full  = {3'b000, beat} << bus_size;
        off       = off_full[OFF_W-1:0];
        bus_addr  = (bus_we ? dst_q : src_q) + ADDR_W'(off);
        last      = ({1'b0, beat} == (cur_beats - 3'd1));
        ld        = (st == ST_READ) && bus_rdy;
        ustep     = ADDR_W'(plan_q.unit_bytes);
        ucnt      = CNT_W'(plan_q.unit_bytes);
        dack      = (st == ST_ACK);
        busy      = (st != ST_IDLE);
        done      = done_q;
        cfg_err   = err_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            plan_q <= '0;
            int_q  <= 1'b0;
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
            beat   <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        if (legal) begin
                            plan_q <= plan_in;
                            int_q  <= internal_in;
                            src_q  <= src_in;
                            dst_q  <= dst_in;
                            cnt_q  <= cnt_in;
                            beat   <= '0;
                            err_q  <= 1'b0;
                            st     <= internal_in ? ST_READ : ST_WAITREQ;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                ST_WAITREQ: if (dreq) st <= ST_ACK;
                ST_ACK:     st <= ST_READ;
                ST_READ: begin
                    if (bus_rdy) begin
                        if (last) begin
                            beat <= '0;
                            st   <= ST_WRITE;
                        end else begin
                            beat <= beat + 1'b1;
                        end
                    end
                end
                ST_WRITE: begin
                    if (bus_rdy) begin
                        if (last) begin
                            beat  <= '0;
                            src_q <= src_q + ustep;
                            dst_q <= dst_q + ustep;
                            cnt_q <= cnt_q - ucnt;
                            if (cnt_q == ucnt) begin
                                st     <= ST_IDLE;
                                done_q <= 1'b1;
                            end else begin
                                st <= int_q ? ST_READ : ST_WAITREQ;
                            end
                        end else begin
                            beat <= beat + 1'b1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dual_addr_dma.sv
module dual_addr_dma
    import dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cfg_unit32,
    input  logic              cfg_internal,
    input  logic              cfg_mem16,
    input  logic [1:0]        cfg_port,
    input  logic [1:0]        cfg_dir,
    input  logic [ADDR_W-1:0] cfg_src,
    input  logic [ADDR_W-1:0] cfg_dst,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              dreq,
    output logic              dack,
    output logic              busy,
    output logic              done,
    output logic              cfg_err,
    output logic              bus_req,
    output logic              bus_we,
    output logic [1:0]        bus_size,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_rdy
);
    localparam int DATA_W = BUS_BYTES * 8;

    logic             legal;
    plan_t            plan;
    logic             ld;
    logic [OFF_W-1:0] off;

    dma_cfg_chk #(.CNT_W(CNT_W)) u_chk (
        .unit32   (cfg_unit32),
        .internal (cfg_internal),
        .mem16    (cfg_mem16),
        .port     (cfg_port),
        .dir      (cfg_dir),
        .count    (cfg_count),
        .legal    (legal),
        .plan     (plan)
    );

    dma_ctl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .legal       (legal),
        .plan_in     (plan),
        .internal_in (cfg_internal),
        .src_in      (cfg_src),
        .dst_in      (cfg_dst),
        .cnt_in      (cfg_count),
        .dreq        (dreq),
        .bus_rdy     (bus_rdy),
        .dack        (dack),
        .busy        (busy),
        .done        (done),
        .cfg_err     (cfg_err),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_size    (bus_size),
        .bus_addr    (bus_addr),
        .ld          (ld),
        .off         (off)
    );

    dma_hold #(.DATA_W(DATA_W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .ld     (ld),
        .ld_off (off),
        .ld_sz  (bus_size),
        .din    (bus_rdata),
        .rd_off (off),
        .dout   (bus_wdata)
    );
endmodule

// File: rtl/dual_addr_dma_sva.sv
module dual_addr_dma_sva #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              dreq,
    input logic              dack,
    input logic              busy,
    input logic              done,
    input logic              cfg_err,
    input logic              bus_req,
    input logic              bus_we,
    input logic [1:0]        bus_size,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rdy
);
    // R4
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dack |=> !dack);

    // R4
    ack_after_req_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dack) |-> $past(dreq));

    // R2
    ack_no_bus_chk: assert property (@(posedge clk) disable iff (rst)
        dack |-> !bus_req);

    // R10
    bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_rdy) |=> (bus_req && $stable(bus_addr)
                                   && $stable(bus_we) && $stable(bus_size)));

    // R10
    size_code_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (bus_size != 2'd3));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !bus_req));

    // R9
    err_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !busy);
endmodule

bind dual_addr_dma dual_addr_dma_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk      (clk),
    .rst      (rst),
    .dreq     (dreq),
    .dack     (dack),
    .busy     (busy),
    .done     (done),
    .cfg_err  (cfg_err),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_size (bus_size),
    .bus_addr (bus_addr),
    .bus_rdy  (bus_rdy)
);

// File: tb/dual_addr_dma_tb.sv
module dual_addr_dma_tb;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              cfg_unit32 = 1'b0, cfg_internal = 1'b0, cfg_mem16 = 1'b0;
    logic [1:0]        cfg_port = '0, cfg_dir = '0;
    logic [ADDR_W-1:0] cfg_src = '0, cfg_dst = '0;
    logic [CNT_W-1:0]  cfg_count = '0;
    logic              dreq = 1'b0;
    logic              dack, busy, done, cfg_err, bus_req, bus_we;
    logic [1:0]        bus_size;
    logic [ADDR_W-1:0] bus_addr;
    logic [31:0]       bus_wdata;
    logic [31:0]       bus_rdata = '0;
    logic              bus_rdy = 1'b0;

    always #4 clk = ~clk;

    dual_addr_dma #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .cfg_unit32(cfg_unit32), .cfg_internal(cfg_internal), .cfg_mem16(cfg_mem16),
        .cfg_port(cfg_port), .cfg_dir(cfg_dir), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
        .cfg_count(cfg_count), .dreq(dreq), .dack(dack), .busy(busy), .done(done),
        .cfg_err(cfg_err), .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy)
    );

    int        n_chk = 0, n_fail = 0;
    int        done_cnt = 0, dack_cnt = 0, cyc = 0;
    bit        stall_en = 1'b0;
    string     cur_req = "R2";
    bit [66:0] expq[$];
    bit        prev_stall = 1'b0;
    bit [31:0] prev_addr = '0;

    function automatic bit [31:0] mem_val(input bit [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h0F1E2D3C;
    endfunction

    function automatic bit [1:0] sz_of(input int b);
        return (b == 1) ? 2'd0 : (b == 2) ? 2'd1 : 2'd2;
    endfunction

    function automatic bit [31:0] mask_of(input bit [1:0] s);
        return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Bus responder and scoreboard monitor
    always @(negedge clk) begin
        bit        rdy;
        bit [66:0] e;
        cyc++;
        if (done) done_cnt++;
        if (dack) dack_cnt++;
        if (prev_stall)
            chk(bus_req && bus_addr == prev_addr, "R10", "request held during stall",
                {31'b0, bus_req, bus_addr}, {31'b0, 1'b1, prev_addr});
        rdy        = !stall_en || (cyc % 3 == 0);
        bus_rdy    = rdy;
        bus_rdata  = mem_val(bus_addr);
        prev_stall = bus_req && !rdy;
        prev_addr  = bus_addr;
        if (bus_req && rdy) begin
            if (expq.size() == 0) begin
                chk(1'b0, cur_req, "unexpected access", {31'b0, bus_we, bus_addr}, '0);
            end else begin
                e = expq.pop_front();
                chk(bus_we == e[66] && bus_size == e[65:64] && bus_addr == e[63:32],
                    cur_req, "access kind/size/addr",
                    {29'b0, bus_we, bus_size, bus_addr}, {29'b0, e[66:32]});
                if (e[66])
                    chk((bus_wdata & mask_of(e[65:64])) == (e[31:0] & mask_of(e[65:64])),
                        cur_req, "write data",
                        {32'b0, bus_wdata & mask_of(e[65:64])},
                        {32'b0, e[31:0] & mask_of(e[65:64])});
            end
        end
    end

    task automatic run_xfer(input bit u32, input bit intl, input bit m16,
                            input bit [1:0] port, input bit [1:0] dir,
                            input bit [31:0] src, input bit [31:0] dst,
                            input bit [15:0] cnt, input bit stall, input string req);
        int ub, pb, mb, rb, wb, units, d0, k0;
        ub    = (u32 || intl) ? 4 : 2;
        pb    = (port == 0) ? 1 : (port == 1) ? 2 : 4;
        mb    = ((u32 || intl) && m16) ? 2 : ub;
        rb    = (dir == 2) ? pb : mb;
        wb    = (dir == 1) ? pb : mb;
        units = cnt / ub;
        for (int u = 0; u < units; u++) begin
            bit [31:0] hold = '0;
            for (int b = 0; b < ub / rb; b++) begin
                bit [31:0] a = src + u * ub + b * rb;
                bit [31:0] v = mem_val(a);
                for (int j = 0; j < rb; j++) hold[(b*rb + j)*8 +: 8] = v[j*8 +: 8];
                expq.push_back({1'b0, sz_of(rb), a, 32'h0});
            end
            for (int b = 0; b < ub / wb; b++) begin
                bit [31:0] a = dst + u * ub + b * wb;
                expq.push_back({1'b1, sz_of(wb), a, hold >> (b * wb * 8)});
            end
        end
        cur_req  = req;
        stall_en = stall;
        d0 = done_cnt;
        k0 = dack_cnt;
        @(negedge clk);
        cfg_unit32 = u32; cfg_internal = intl; cfg_mem16 = m16;
        cfg_port = port; cfg_dir = dir; cfg_src = src; cfg_dst = dst; cfg_count = cnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !cfg_err, "R9", "legal start accepted and error clear",
            {62'b0, busy, cfg_err}, 64'h2);
        if (!intl) begin
            repeat (3) @(negedge clk);
            chk(!bus_req && !dack, "R4", "idle while request low",
                {62'b0, bus_req, dack}, 64'h0);
            for (int u = 0; u < units; u++) begin
                dreq = 1'b1;
                wait (dack_cnt == k0 + u + 1);
                dreq = 1'b0;
            end
        end
        wait (done_cnt == d0 + 1);
        @(negedge clk);
        chk(expq.size() == 0, req, "all expected accesses issued",
            64'(expq.size()), 64'h0);
        chk(dack_cnt - k0 == (intl ? 0 : units), intl ? "R3" : "R4",
            "acknowledge count", 64'(dack_cnt - k0), 64'(intl ? 0 : units));
        dreq = !intl;
        repeat (4) @(negedge clk);
        chk(!busy && !bus_req && !dack && done_cnt == d0 + 1, "R8",
            "stopped after final unit",
            {61'b0, busy, bus_req, dack}, 64'h0);
        dreq = 1'b0;
        stall_en = 1'b0;
        expq.delete();
    endtask

    task automatic bad_cfg(input bit u32, input bit intl, input bit [1:0] port,
                           input bit [1:0] dir, input bit [15:0] cnt, input string what);
        @(negedge clk);
        cfg_unit32 = u32; cfg_internal = intl; cfg_mem16 = 1'b0;
        cfg_port = port; cfg_dir = dir; cfg_count = cnt;
        cfg_src = 32'h100; cfg_dst = 32'h200;
        start = 1'b1;
        dreq = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(cfg_err && !busy, "R9", what, {62'b0, cfg_err, busy}, 64'h2);
        repeat (3) @(negedge clk);
        chk(!busy && !bus_req && !dack, "R9", {what, " stays idle"},
            {61'b0, busy, bus_req, dack}, 64'h0);
        dreq = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !dack && !cfg_err && !bus_req, "R1", "reset outputs",
            {59'b0, busy, done, dack, cfg_err, bus_req}, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        // R5 word unit memory to memory
        run_xfer(1, 0, 0, 2'd2, 2'd0, 32'h1000, 32'h2000, 16'd8, 0, "R5");
        // R3 halfword unit memory to memory
        run_xfer(0, 0, 0, 2'd2, 2'd0, 32'h1100, 32'h2100, 16'd6, 0, "R3");
        // R6 byte port packing into word, with stalls for R10
        run_xfer(1, 0, 0, 2'd0, 2'd2, 32'h3000, 32'h4000, 16'd8, 1, "R6");
        // R7 halfword port and 16-bit memory, memory to I/O
        run_xfer(1, 0, 1, 2'd1, 2'd1, 32'h5000, 32'h6000, 16'd8, 0, "R7");
        // R6 byte port, halfword unit, memory to I/O
        run_xfer(0, 0, 0, 2'd0, 2'd1, 32'h5100, 32'h6100, 16'd4, 1, "R6");
        // R5 equal port and unit, I/O to memory
        run_xfer(1, 0, 0, 2'd2, 2'd2, 32'h7000, 32'h7800, 16'd4, 0, "R5");
        // R7 16-bit memory on both sides
        run_xfer(1, 0, 1, 2'd2, 2'd0, 32'h8000, 32'h9000, 16'd8, 0, "R7");
        // R9 illegal configurations
        bad_cfg(0, 0, 2'd2, 2'd2, 16'd4, "port wider than unit");
        bad_cfg(1, 0, 2'd0, 2'd3, 16'd4, "reserved direction");
        bad_cfg(1, 0, 2'd3, 2'd1, 16'd4, "reserved port code");
        bad_cfg(1, 0, 2'd0, 2'd0, 16'd0, "zero count");
        bad_cfg(1, 0, 2'd0, 2'd0, 16'd6, "count not multiple of unit");
        // R3 internal source forces word unit: legal with 32-bit port
        run_xfer(0, 1, 0, 2'd2, 2'd2, 32'hA000, 32'hB000, 16'd12, 0, "R3");
        // R8 longer run with stalls
        run_xfer(1, 0, 0, 2'd1, 2'd2, 32'hC000, 32'hD000, 16'd16, 1, "R8");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R8 watchdog: actual still running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule